// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Controller

This block gathers 64 interrupt sources into two banks of 32 and forwards them to a CPU as a single request line. Each bank keeps a latch of captured edge events, a software-written enable mask, a write-one-to-clear acknowledge port and a live view of the raw input lines. Inside each bank, a fixed compile-time mask marks some sources as level-sensitive. Those sources are taken straight from the raw line and never pass through the event latch.

A source is pending when its latched event or its masked raw level is set and its enable bit is set. The CPU line is high whenever any source is pending. A registered pending number names the highest-numbered pending source and carries a valid flag. Software reaches the registers through a small 32-bit bus with a byte address inside a 64-byte window. After reset every enable bit is clear, so nothing is forwarded until software opens sources one by one.

Top module: `irqc_top`

## Requirements
- R1: Source n sits in bank n/32 at bit n mod 32. Bank 0 occupies byte offsets 0x20–0x2F and bank 1 occupies 0x10–0x1F. Inside a bank the registers sit at these offsets: event 0x0, enable 0x4, acknowledge 0x8, raw level 0xC. A read of any other offset returns 0. Read data appears on `reg_rdata_o` one clock after the clock edge that samples `reg_re_i`.
- R2: After reset, both enable masks and both event latches read 0, `irq_o` is 0 and `pend_valid_o` is 0.
- R3: A 0-to-1 change on an edge-type source whose enable bit is set sets that source's event bit at the clock edge where the change is seen. `irq_o` rises in the same cycle.
- R4: If the enable bit is set while the source line is already high, the event bit is not set and no request is raised. Only a later rising edge is latched.
- R5: Writing 1 to a bit of the acknowledge register clears that bit's event latch. Writing 0 to a bit leaves it unchanged.
- R6: If an acknowledge write and a new latched edge hit the same bit in the same cycle, the bit ends up set.
- R7: Level-sensitive sources use the default masks 0x3FF00000 for bank 0 and 0x1FF00000 for bank 1. A level-sensitive source is pending while its raw line is high and its enable bit is set. Its event bit always reads 0, and an acknowledge does not remove it.
- R8: A bank's pending word is (event | (raw & level_mask)) & enable. `irq_o` is the OR of both pending words, with no register on the way. Clearing an enable bit hides a latched event but does not clear it.
- R9: `pend_id_o` gives the highest global index among pending sources, and `pend_valid_o` shows that some source is pending. Both are registered, so they follow the pending state one clock later.
- R10: Writes to the event and raw level registers, and writes to unmapped offsets, change nothing.
- R11: The raw level register returns the current state of the bank's 32 input lines, whether or not they are enabled.
- R12: An edge on an edge-type source whose enable bit is clear is not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 64 | Interrupt source lines, synchronous to clk_i |
| reg_addr_i | input | 6 | Byte address inside the 64-byte window |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the CPU |
| pend_id_o | output | 6 | Number of the highest pending source |
| pend_valid_o | output | 1 | pend_id_o names a real pending source |

## Verification
The assertions assume that the source lines are already synchronous to the clock. They also assume that write and read strobes last one cycle, with address and data stable around the sampling edge. The bench drives every source change and every strobe on the falling clock edge, so each change is seen at exactly one rising edge. The bench samples on the falling edge as well. Edge cases that need a specific order are built explicitly: an enable written while a line is already high, and an acknowledge that lands in the same cycle as a new edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    REG_EVT = 2'd0,
    REG_EN  = 2'd1,
    REG_ACK = 2'd2,
    REG_LVL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int          BANK_W   = 32,
  parameter int          ADDR_W   = 6,
  parameter int          BASE     = 32,
  parameter logic [31:0] LVL_MASK = 32'h3FF0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [BANK_W-1:0] rdata_o,
  output logic [BANK_W-1:0] pend_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [BANK_W-1:0] LVL    = LVL_MASK[BANK_W-1:0];

  logic [BANK_W-1:0] src_q, evt_q, en_q;
  logic [BANK_W-1:0] rise, set_v, ack_v;
  reg_sel_e          sel;

  assign hit_o = (addr_i[ADDR_W-1:4] == BASE_A[ADDR_W-1:4]);
  assign sel   = reg_sel_e'(addr_i[3:2]);
  assign rise  = src_i & ~src_q;
  assign set_v = rise & en_q & ~LVL;
  assign ack_v = (we_i && hit_o && sel == REG_ACK) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      evt_q <= '0;
      en_q  <= '0;
    end else begin
      src_q <= src_i;
      // set wins over a same-cycle acknowledge
      evt_q <= (evt_q & ~ack_v) | set_v;
      if (we_i && hit_o && sel == REG_EN) en_q <= wdata_i;
    end
  end

  assign pend_o = (evt_q | (src_i & LVL)) & en_q;

  always_comb begin
    unique case (sel)
      REG_EVT: rdata_o = evt_q;
      REG_EN:  rdata_o = en_q;
      REG_LVL: rdata_o = src_i;
      default: rdata_o = '0;
    endcase
  end

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & $past(set_v)) == $past(set_v)));
  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & $past(ack_v & ~set_v)) == '0));
  a_r12_no_spurious_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(src_i & ~src_q & en_q)) == '0));
  a_r7_level_never_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q & LVL) == '0);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] id_o,
  output logic          any_o
);
  always_comb begin
    id_o = '0;
    for (int i = 0; i < N; i++)
      if (vec_i[i]) id_o = IW'(i);  // later (higher) index overrides
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int                          NUM_BANKS = 2,
  parameter int                          BANK_W    = 32,
  parameter int                          ADDR_W    = 6,
  parameter logic [NUM_BANKS-1:0][31:0]  LVL_MASKS = {32'h1FF0_0000, 32'h3FF0_0000},
  localparam int                         NSRC      = NUM_BANKS * BANK_W,
  localparam int                         IW        = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   irq_src_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic [IW-1:0]     pend_id_o,
  output logic              pend_valid_o
);
  localparam int STRIDE = 16;

  logic [NSRC-1:0]                 pend_all;
  logic [NUM_BANKS-1:0]            hit;
  logic [NUM_BANKS-1:0][BANK_W-1:0] rd_b;
  logic [31:0]                     rd_mux;
  logic [IW-1:0]                   enc_id;
  logic                            enc_any;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqc_bank #(
      .BANK_W  (BANK_W),
      .ADDR_W  (ADDR_W),
      .BASE    (NUM_BANKS * STRIDE - b * STRIDE),
      .LVL_MASK(LVL_MASKS[b])
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (irq_src_i[b*BANK_W +: BANK_W]),
      .addr_i (reg_addr_i),
      .we_i   (reg_we_i),
      .wdata_i(reg_wdata_i[BANK_W-1:0]),
      .hit_o  (hit[b]),
      .rdata_o(rd_b[b]),
      .pend_o (pend_all[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (hit[b]) rd_mux = 32'(rd_b[b]);
  end

  irqc_prio #(.N(NSRC), .IW(IW)) u_prio (
    .vec_i(pend_all),
    .id_o (enc_id),
    .any_o(enc_any)
  );

  assign irq_o = enc_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rdata_o  <= '0;
      pend_id_o    <= '0;
      pend_valid_o <= 1'b0;
    end else begin
      if (reg_re_i) reg_rdata_o <= rd_mux;
      pend_id_o    <= enc_id;
      pend_valid_o <= enc_any;
    end
  end

  a_r9_id_is_highest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> (($past(pend_all) >> pend_id_o) == NSRC'(1)));
  a_r9_valid_follows_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |=> pend_valid_o);
  a_r1_single_bank_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] irq_src_i = '0;
  logic [5:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic        reg_re_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic [5:0]  pend_id_o;
  logic        pend_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irqc_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(irq_src_i),
    .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .pend_id_o(pend_id_o), .pend_valid_o(pend_valid_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_re_i = 1'b1;
    @(negedge clk_i);
    reg_re_i = 1'b0;
    d = reg_rdata_o;
  endtask

  task automatic src(input int n, input logic v);
    @(negedge clk_i);
    irq_src_i[n] = v;
  endtask

  task automatic clean();
    @(negedge clk_i);
    irq_src_i = '0;
    wr(6'h24, 32'h0); wr(6'h14, 32'h0);
    wr(6'h28, 32'hFFFF_FFFF); wr(6'h18, 32'hFFFF_FFFF);
    idle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R2 irq_o", irq_o, 0);
    check("R2 pend_valid_o", pend_valid_o, 0);
    rd(6'h24, d); check("R2 enable bank0", d, 0);
    rd(6'h14, d); check("R2 enable bank1", d, 0);
    rd(6'h20, d); check("R2 event bank0", d, 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(6'h24, 32'h0000_1234); wr(6'h14, 32'hABCD_0000);
    rd(6'h24, d); check("R1 bank0 enable at 0x24", d, 32'h0000_1234);
    rd(6'h14, d); check("R1 bank1 enable at 0x14", d, 32'hABCD_0000);
    rd(6'h04, d); check("R1 unmapped 0x04", d, 0);
    rd(6'h34, d); check("R1 unmapped 0x34", d, 0);
    wr(6'h34, 32'hFFFF_FFFF);
    rd(6'h24, d); check("R10 unmapped write", d, 32'h0000_1234);
    clean();
  endtask

  task automatic t_edge_ack();
    logic [31:0] d;
    wr(6'h24, 32'h8);
    src(3, 1'b1);
    idle(1);
    check("R3 irq_o after edge", irq_o, 1);
    rd(6'h20, d); check("R3 event bit 3", d, 32'h8);
    check("R9 id 3", {pend_valid_o, pend_id_o}, {1'b1, 6'd3});
    wr(6'h28, 32'h0);
    rd(6'h20, d); check("R5 ack zero no effect", d, 32'h8);
    wr(6'h28, 32'h8);
    rd(6'h20, d); check("R5 ack clears", d, 0);
    check("R5 irq_o after ack", irq_o, 0);
    clean();
  endtask

  task automatic t_disabled_and_late_enable();
    logic [31:0] d;
    src(5, 1'b1); idle(2);
    rd(6'h20, d); check("R12 disabled edge ignored", d, 0);
    check("R12 irq_o", irq_o, 0);
    wr(6'h24, 32'h20); idle(2);
    rd(6'h20, d); check("R4 enable while high no event", d, 0);
    check("R4 irq_o", irq_o, 0);
    src(5, 1'b0); idle(1); src(5, 1'b1); idle(1);
    rd(6'h20, d); check("R4 later edge latched", d, 32'h20);
    check("R4 irq_o later edge", irq_o, 1);
    clean();
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    wr(6'h24, 32'h80);
    src(7, 1'b1); idle(1); src(7, 1'b0); idle(1);
    @(negedge clk_i);
    irq_src_i[7] = 1'b1;
    reg_addr_i = 6'h28; reg_wdata_i = 32'h80; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    rd(6'h20, d); check("R6 set wins over ack", d, 32'h80);
    wr(6'h28, 32'h80);
    rd(6'h20, d); check("R6 plain ack afterwards clears", d, 0);
    clean();
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(6'h24, 32'h0040_0000);
    src(22, 1'b1);
    #1 check("R7 level irq_o immediate", irq_o, 1);
    rd(6'h20, d); check("R7 level not latched", d, 0);
    wr(6'h28, 32'h0040_0000); idle(1);
    check("R7 ack cannot remove level", irq_o, 1);
    check("R9 id 22", {pend_valid_o, pend_id_o}, {1'b1, 6'd22});
    src(22, 1'b0);
    #1 check("R7 level drops", irq_o, 0);
    wr(6'h14, 32'h2000_0000);
    src(61, 1'b1); idle(1);
    rd(6'h10, d); check("R7 bank1 bit29 is edge", d, 32'h2000_0000);
    clean();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(6'h24, 32'h10);
    src(4, 1'b1); idle(1); src(4, 1'b0); idle(1);
    check("R8 irq_o latched", irq_o, 1);
    wr(6'h24, 32'h0); idle(1);
    check("R8 disable hides event", irq_o, 0);
    rd(6'h20, d); check("R8 event kept", d, 32'h10);
    wr(6'h24, 32'h10);
    check("R8 re-enable shows event", irq_o, 1);
    clean();
  endtask

  task automatic t_prio();
    wr(6'h24, 32'h8); wr(6'h14, 32'h2);
    @(negedge clk_i);
    irq_src_i[3] = 1'b1; irq_src_i[33] = 1'b1;
    idle(3);
    check("R9 highest is 33", {pend_valid_o, pend_id_o}, {1'b1, 6'd33});
    wr(6'h18, 32'h2); idle(2);
    check("R9 falls back to 3", {pend_valid_o, pend_id_o}, {1'b1, 6'd3});
    clean();
    check("R9 valid low when idle", pend_valid_o, 0);
  endtask

  task automatic t_readonly_raw();
    logic [31:0] d;
    wr(6'h24, 32'h8);
    src(3, 1'b1); idle(1);
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, d); check("R10 event write ignored", d, 32'h8);
    wr(6'h2C, 32'h0);
    rd(6'h2C, d); check("R10 level write ignored", d, 32'h8);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, d); check("R10 bank1 event write ignored", d, 0);
    clean();
    @(negedge clk_i);
    irq_src_i = 64'hDEAD_BEEF_0123_4567;
    rd(6'h2C, d); check("R11 bank0 raw", d, 32'h0123_4567);
    rd(6'h1C, d); check("R11 bank1 raw", d, 32'hDEAD_BEEF);
    check("R11 raw does not request", irq_o, 0);
    clean();
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_map();
    t_edge_ack();
    t_disabled_and_late_enable();
    t_set_wins();
    t_level();
    t_mask();
    t_prio();
    t_readonly_raw();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule